// File: doc/BRIEF.md
# Counter Test Pattern Source

This block is a debug stimulus generator that stands in for live converter or channelizer data at the head of a capture chain. On every clock where it is told to advance, it emits a group of parallel complex samples, each a 16-bit real part and a 16-bit imaginary part. The real part is the sample's own position inside a fixed-length frame. The imaginary part is the number of the frame it belongs to.

Because each sample carries its own position, the capture, packing and DMA stages downstream can be checked from the stored data alone. Gaps, reorderings and lost frame boundaries show up as breaks in the counting. A software trigger restarts the pattern from sample 0 of frame 0, so a capture window can be lined up with a known starting point.

Top module: `ctp_source`

## Requirements
- R1: After reset `smp_vld_o` is low and `smp_o` is all zeros, and the first sample group emitted after reset starts at index 0 of frame 0.
- R2: In one emitted group, lane k carries sample index n+k, so lane 0 holds the lowest index of the cycle.
- R3: Across lanes and across emitting cycles, the real part rises by exactly +1 from each sample to the next, except at a frame wrap.
- R4: The sample index runs from 0 to FRAME_LEN-1 and then returns to 0, which is a step of -(FRAME_LEN-1). FRAME_LEN is a multiple of LANES, so a wrap always falls between cycles.
- R5: All lanes of a group carry the same frame number. The frame number rises by exactly one on the first group after each index wrap and stays the same at every other group.
- R6: The frame number is FRAME_W bits wide and wraps modulo 2^FRAME_W, returning to 0 after its largest value.
- R7: `trig_i` high on an edge clears both counters and emits no group, even when `adv_i` is also high. The next emitted group starts at index 0 of frame 0.
- R8: On an edge where `adv_i` is low and `trig_i` is low, no group is emitted: `smp_vld_o` goes low, `smp_o` keeps its previous value, and the pattern does not advance.
- R9: A group is registered. `smp_vld_o` and the new `smp_o` appear one clock edge after the edge on which `adv_i` was sampled high with `trig_i` low.
- R10: Lane k occupies `smp_o[32k+31:32k]`. The real part sits in the lower 16 bits and the imaginary part in the upper 16 bits, and both are unsigned counts zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| trig_i | input | 1 | Software restart: clears the sample and frame counters |
| adv_i | input | 1 | Advance: emit one group and step the pattern on this edge |
| smp_vld_o | output | 1 | A new sample group is present on `smp_o` |
| smp_o | output | LANES*32 | Packed complex samples, one 32-bit word per lane |

## Verification
Every result of this block is due exactly one edge after the inputs that caused it. A group, its valid flag, a held value and the effect of a trigger all appear on the edge after `adv_i` or `trig_i` was sampled. The bench drives the inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. A model in the bench steps forward in the same order. Because the bench uses a small frame and a narrow frame counter, several complete frame-number wraps fit into the run, so the index wrap, the frame wrap and the restart are all seen at the ports.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  // one complex sample: imaginary in the upper half, real in the lower half
  typedef struct packed {
    logic [15:0] im;
    logic [15:0] re;
  } ctp_iq_t;

  localparam int unsigned CTP_IQ_W   = 32;
  localparam int unsigned CTP_PART_W = 16;
endpackage

// File: rtl/ctp_index_ctr.sv
module ctp_index_ctr #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned FRAME_LEN = 512,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] base_o,
  output logic             wrap_o
);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(LANES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - LANES);

  logic [IDX_W-1:0] base_q, base_d;
  logic             at_last;

  assign at_last = (base_q == LAST);

  always_comb begin
    base_d = base_q;
    if (clr_i)       base_d = '0;
    else if (step_i) base_d = at_last ? '0 : base_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign base_o = base_q;
  assign wrap_o = step_i & ~clr_i & at_last;

  // R4: the last group of a frame is followed by index 0
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && base_q == LAST) |=> (base_q == '0));
  // R8: no step, no change
  a_r8_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(base_q));
  // R7: restart clears the index
  a_r7_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (base_q == '0));
  // R3: a step moves the index by one group
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && base_q != LAST) |=> (base_q == $past(base_q) + STEP));
endmodule

// File: rtl/ctp_frame_ctr.sv
module ctp_frame_ctr #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wrap_i,
  output logic [FRAME_W-1:0] frm_o
);
  logic [FRAME_W-1:0] frm_q, frm_d;

  always_comb begin
    frm_d = frm_q;
    if (clr_i)       frm_d = '0;
    else if (wrap_i) frm_d = frm_q + FRAME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_q <= '0;
    else        frm_q <= frm_d;
  end

  assign frm_o = frm_q;

  // R5: one increment per index wrap
  a_r5_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !clr_i) |=> (frm_q == $past(frm_q) + FRAME_W'(1)));
  // R5: no change away from a wrap
  a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && !clr_i) |=> $stable(frm_q));
  // R7: restart clears the frame number
  a_r7_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (frm_q == '0));
endmodule

// File: rtl/ctp_lane_fmt.sv
module ctp_lane_fmt
  import ctp_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned FRAME_LEN = 512,
  parameter int unsigned FRAME_W   = 16,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic [IDX_W-1:0]          base_i,
  input  logic [FRAME_W-1:0]        frm_i,
  output logic [LANES*CTP_IQ_W-1:0] word_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ctp_iq_t          smp;
    logic [IDX_W-1:0] idx;
    assign idx    = base_i + IDX_W'(k);
    assign smp.re = CTP_PART_W'(idx);
    assign smp.im = CTP_PART_W'(frm_i);
    assign word_o[k*CTP_IQ_W +: CTP_IQ_W] = smp;
  end
endmodule

// File: rtl/ctp_source.sv
module ctp_source
  import ctp_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned FRAME_LEN = 512,
  parameter int unsigned FRAME_W   = 16,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN),
  localparam int unsigned OUT_W    = LANES * CTP_IQ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             adv_i,
  output logic             smp_vld_o,
  output logic [OUT_W-1:0] smp_o
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic             emit;
  logic [IDX_W-1:0] base;
  logic [FRAME_W-1:0] frm;
  logic             wrap;
  logic [OUT_W-1:0] word;

  assign emit = adv_i & ~trig_i;

  ctp_index_ctr #(.LANES(LANES), .FRAME_LEN(FRAME_LEN)) u_idx (
    .clk(clk), .rst_n(rst_s), .clr_i(trig_i), .step_i(adv_i),
    .base_o(base), .wrap_o(wrap)
  );

  ctp_frame_ctr #(.FRAME_W(FRAME_W)) u_frm (
    .clk(clk), .rst_n(rst_s), .clr_i(trig_i), .wrap_i(wrap), .frm_o(frm)
  );

  ctp_lane_fmt #(.LANES(LANES), .FRAME_LEN(FRAME_LEN), .FRAME_W(FRAME_W)) u_fmt (
    .base_i(base), .frm_i(frm), .word_o(word)
  );

  // output register
  logic             vld_q, vld_d;
  logic [OUT_W-1:0] out_q, out_d;

  always_comb begin
    vld_d = emit;
    out_d = emit ? word : out_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      out_q <= out_d;
    end
  end

  assign smp_vld_o = vld_q;
  assign smp_o     = out_q;

  // R9: an accepted advance shows up on the next edge
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_s)
    (adv_i && !trig_i) |=> smp_vld_o);
  // R8 / R7: no group emitted, data held
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !(adv_i && !trig_i) |=> (!smp_vld_o && $stable(smp_o)));
  // R2: lane 0 of an emitted group is aligned to a group boundary
  a_r2_lane0_aligned: assert property (@(posedge clk) disable iff (!rst_s)
    smp_vld_o |-> (smp_o[1:0] == 2'(0) || LANES != 4));

  initial begin
    a_r4_len_multiple: assert (FRAME_LEN % LANES == 0 && FRAME_W <= 16);
  end
endmodule

// File: tb/ctp_source_tb.sv
module ctp_source_tb;
  localparam int unsigned LANES     = 4;
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned FRAME_W   = 4;
  localparam int unsigned FRM_MOD   = 1 << FRAME_W;
  localparam int unsigned OUT_W     = LANES * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic adv = 1'b0;
  logic vld;
  logic [OUT_W-1:0] dout;

  always #2.5 clk = ~clk;

  ctp_source #(.LANES(LANES), .FRAME_LEN(FRAME_LEN), .FRAME_W(FRAME_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .adv_i(adv),
    .smp_vld_o(vld), .smp_o(dout)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_idx = 0;
  int m_frm = 0;
  int prev_last = -1;
  bit first_pending = 1'b1;
  string first_tag = "R1";
  bit frm_wrapped = 1'b0;
  logic [OUT_W-1:0] held = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic t);
    adv  = e;
    trig = t;
    @(posedge clk);
    @(negedge clk);
    if (t) begin
      // R7: restart emits nothing and keeps the data
      chk("R7", {31'd0, vld}, 32'd0);
      chk("R7", dout[31:0], held[31:0]);
      m_idx = 0; m_frm = 0; prev_last = -1;
      first_pending = 1'b1; first_tag = "R7";
    end else if (e) begin
      chk("R9", {31'd0, vld}, 32'd1);
      for (int k = 0; k < LANES; k++) begin
        logic [31:0] w;
        w = dout[k*32 +: 32];
        chk("R2", {16'd0, w[15:0]}, 32'(m_idx + k));
        chk("R5", {16'd0, w[31:16]}, 32'(m_frm));
        chk("R10", w, {16'(m_frm), 16'(m_idx + k)});
      end
      if (first_pending) begin
        chk(first_tag, dout[31:0], 32'd0);
        first_pending = 1'b0;
      end
      if (prev_last >= 0) begin
        if (prev_last == FRAME_LEN - 1) chk("R4", {16'd0, dout[15:0]}, 32'd0);
        else                            chk("R3", {16'd0, dout[15:0]}, 32'(prev_last + 1));
      end
      if (frm_wrapped && m_idx == 0 && m_frm == 0) begin
        chk("R6", {16'd0, dout[31:16]}, 32'd0);
        frm_wrapped = 1'b0;
      end
      prev_last = m_idx + LANES - 1;
      held = dout;
      m_idx = m_idx + LANES;
      if (m_idx == FRAME_LEN) begin
        m_idx = 0;
        m_frm = m_frm + 1;
        if (m_frm == FRM_MOD) begin
          m_frm = 0;
          frm_wrapped = 1'b1;
        end
      end
    end else begin
      chk("R8", {31'd0, vld}, 32'd0);
      chk("R8", dout[31:0], held[31:0]);
      chk("R8", dout[OUT_W-1 -: 32], held[OUT_W-1 -: 32]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    chk("R1", {31'd0, vld}, 32'd0);
    chk("R1", dout[31:0], 32'd0);
    chk("R1", dout[OUT_W-1 -: 32], 32'd0);

    // continuous run across more than one frame-number wrap
    for (int i = 0; i < 80; i++) step(1'b1, 1'b0);
    // gapped advance
    for (int i = 0; i < 60; i++) step((i % 3) != 2, 1'b0);
    // restart together with advance, mid-frame
    step(1'b1, 1'b1);
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
    // restart with no advance, then idle, then back-to-back restarts
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    // long run for a second frame-number wrap after restart
    for (int i = 0; i < 140; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule